// File: doc/BRIEF.md
# Quadrature Position Counter with Capture and Compare

This block follows one motion axis. It decodes the two phase signals of an incremental position encoder into a signed 32-bit position count that a host can read. The host can also overwrite the count with a new value. Each encoder phase and an external capture input is first passed through a two-flop synchroniser and a three-sample majority filter. Only after that does any edge detection take place, so glitches one sample wide never reach the counter.

A capture input event copies the live count into a capture register and sets a valid flag. The host can choose whether the rising or the falling edge counts as the event. A compare register holds a target position. On the cycle the count arrives at that target, the block drives a one-cycle output pulse and sets a sticky hit flag. Four word registers are reached through a plain read/write port: position, capture, compare and control/status.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset, the position, capture and compare registers read 0, and the status word reads 0.
- R2: The phase pair is written as {A,B}. Stepping through 00, 01, 11, 10 and back to 00 adds 1 to the count at each step. The reverse order subtracts 1 at each step.
- R3: A change of both phases at once leaves the count unchanged and sets the error flag (status bit 1). The flag stays set until a control write with bit 1 set clears it.
- R4: A phase pulse that lasts a single clock cycle does not change the count.
- R5: A write to address 0 loads the count with the written data.
- R6: When a preload and a count step fall in the same cycle, the count takes the preload value and the step is lost.
- R7: The count wraps in two's complement: one step up from 0x7FFFFFFF gives 0x80000000, and one step down returns to 0x7FFFFFFF.
- R8: A capture event copies the count into the capture register (address 1) and sets capture-valid (status bit 3). A read of address 1 clears capture-valid.
- R9: Control bit 0 selects the capture edge: 0 selects rising and 1 selects falling. An edge of the other kind captures nothing.
- R10: When the count changes to equal the compare value (address 2), `cmp_evt` pulses for exactly one cycle and the hit flag (status bit 2) is set. No further pulse comes while the count stays equal. A control write with bit 2 set clears the hit flag.
- R11: Writing the compare register with a value equal to the current, unchanged count gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| cap_in | input | 1 | Capture event input, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears capture-valid on address 1) |
| bus_addr | input | 2 | Register select: 0 position, 1 capture, 2 compare, 3 control/status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register, combinational |
| cmp_evt | output | 1 | One-cycle pulse when the count arrives at the compare value |

## Verification
The case that is hardest to reach is a preload landing in exactly the cycle in which a filtered encoder edge moves the count. An encoder edge first travels through the synchroniser, the majority filter and the decoder before the counter moves. The stimulus uses that fixed path latency: it changes a phase and counts five falling clock edges. It then raises the write strobe, so the write is sampled on the same rising edge as the step. A final read of the count must show the preload value, not that value plus one.

// File: rtl/qpc_pkg.sv
// Shared definitions for the quadrature position counter.
// Assumes a two-bit register address and a fixed status bit layout.
package qpc_pkg;
    typedef enum logic [1:0] {
        REG_POS = 2'd0,
        REG_CAP = 2'd1,
        REG_CMP = 2'd2,
        REG_CTL = 2'd3
    } reg_sel_e;

    localparam int CTL_CAP_FALL = 0;
    localparam int CTL_ERR      = 1;
    localparam int CTL_HIT      = 2;
    localparam int CTL_CAPVAL   = 3;

    // Majority vote of three samples.
    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    // Gray phase pair {a,b} to a position modulo 4.
    function automatic logic [1:0] gray_pos(input logic [1:0] ab);
        case (ab)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/qpc_cond.sv
// Input conditioner: a synchroniser chain, then a three-sample majority filter.
// Assumes raw inputs are asynchronous. Latency is SYNC_STAGES + 3 clocks to a
// settled output; single-sample pulses are removed.
module qpc_cond #(
    parameter int N           = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] clean
);
    import qpc_pkg::*;

    for (genvar g = 0; g < N; g++) begin : g_ch
        logic [SYNC_STAGES-1:0] sy;
        logic [2:0]             hist;

        // Synchronise, shift the sample history and register the vote.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sy       <= '0;
                hist     <= '0;
                clean[g] <= 1'b0;
            end else begin
                sy       <= {sy[SYNC_STAGES-2:0], raw[g]};
                hist     <= {hist[1:0], sy[SYNC_STAGES-1]};
                clean[g] <= maj3(hist);
            end
        end
    end
endmodule

// File: rtl/qpc_quad_step.sv
// 4x quadrature step decoder. It compares the filtered phase pair with the pair
// seen on the previous cycle. Assumes a and b are already clean and synchronous.
module qpc_quad_step (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic step_up,
    output logic step_dn,
    output logic illegal
);
    import qpc_pkg::*;

    logic [1:0] prev_q;
    logic [1:0] delta;

    // Remember the last phase pair.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 2'b00;
        else        prev_q <= {a, b};
    end

    // Classify the position difference modulo 4.
    always_comb begin
        delta   = gray_pos({a, b}) - gray_pos(prev_q);
        step_up = (delta == 2'd1);
        step_dn = (delta == 2'd3);
        illegal = (delta == 2'd2);
    end
endmodule

// File: rtl/quad_pos_counter.sv
// Top of the quadrature position counter: count, preload, capture, compare and
// the register port. Assumes one clock domain. Reads are combinational, and a
// strobed read of the capture register clears capture-valid.
module quad_pos_counter #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             cap_in,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             cmp_evt
);
    import qpc_pkg::*;

    localparam int NIN = 3;

    logic [NIN-1:0]   raw, clean;
    logic             step_up, step_dn, illegal;
    logic [CNT_W-1:0] cnt_q, cnt_next, cap_q, cmp_q, cmp_next;
    logic             cap_fall_q, err_q, hit_q, cap_valid_q, cap_prev_q, cmp_pulse_q;
    logic             wr_pos, wr_cmp, wr_ctl, rd_cap, cap_fire, cnt_moves, arrive;

    assign raw = {cap_in, enc_b, enc_a};

    qpc_cond #(.N(NIN), .SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw),
        .clean (clean)
    );

    qpc_quad_step u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .a       (clean[0]),
        .b       (clean[1]),
        .step_up (step_up),
        .step_dn (step_dn),
        .illegal (illegal)
    );

    // Decode the register strobes.
    always_comb begin
        wr_pos = bus_wr && (bus_addr == REG_POS);
        wr_cmp = bus_wr && (bus_addr == REG_CMP);
        wr_ctl = bus_wr && (bus_addr == REG_CTL);
        rd_cap = bus_rd && (bus_addr == REG_CAP);
    end

    // Next count: a preload takes priority over a step.
    always_comb begin
        if (wr_pos)       cnt_next = bus_wdata;
        else if (step_up) cnt_next = cnt_q + 1'b1;
        else if (step_dn) cnt_next = cnt_q - 1'b1;
        else              cnt_next = cnt_q;
        cmp_next  = wr_cmp ? bus_wdata : cmp_q;
        cnt_moves = (cnt_next != cnt_q);
        arrive    = cnt_moves && (cnt_next == cmp_next);
        cap_fire  = cap_fall_q ? (cap_prev_q && !clean[2]) : (!cap_prev_q && clean[2]);
    end

    // Count, compare value and compare event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            cmp_q       <= '0;
            cmp_pulse_q <= 1'b0;
        end else begin
            cnt_q       <= cnt_next;
            cmp_q       <= cmp_next;
            cmp_pulse_q <= arrive;
        end
    end

    // Capture register and its valid flag; a new capture wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q       <= '0;
            cap_valid_q <= 1'b0;
            cap_prev_q  <= 1'b0;
        end else begin
            cap_prev_q <= clean[2];
            if (cap_fire) begin
                cap_q       <= cnt_q;
                cap_valid_q <= 1'b1;
            end else if (rd_cap) begin
                cap_valid_q <= 1'b0;
            end
        end
    end

    // Control bit and sticky flags; setting wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_fall_q <= 1'b0;
            err_q      <= 1'b0;
            hit_q      <= 1'b0;
        end else begin
            if (wr_ctl) cap_fall_q <= bus_wdata[CTL_CAP_FALL];
            if (illegal)                             err_q <= 1'b1;
            else if (wr_ctl && bus_wdata[CTL_ERR])   err_q <= 1'b0;
            if (arrive)                              hit_q <= 1'b1;
            else if (wr_ctl && bus_wdata[CTL_HIT])   hit_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_POS: bus_rdata = cnt_q;
            REG_CAP: bus_rdata = cap_q;
            REG_CMP: bus_rdata = cmp_q;
            default: begin
                bus_rdata[CTL_CAP_FALL] = cap_fall_q;
                bus_rdata[CTL_ERR]      = err_q;
                bus_rdata[CTL_HIT]      = hit_q;
                bus_rdata[CTL_CAPVAL]   = cap_valid_q;
            end
        endcase
    end

    assign cmp_evt = cmp_pulse_q;
endmodule

// File: rtl/qpc_checks.sv
// Property checker for quad_pos_counter, attached by bind. It watches the count,
// the compare value, the decoder flags and the register port.
module qpc_checks #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic             cmp_evt,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             illegal,
    input logic             cap_fire,
    input logic             cap_valid
);
    logic preload;
    assign preload = bus_wr && (bus_addr == 2'd0);

    // R2: without a preload the count moves by at most one per cycle.
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !preload |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 ||
                      cnt_q == $past(cnt_q) - 1'b1));

    // R3: an illegal transition never moves the count.
    a_r3_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && !preload) |=> $stable(cnt_q));

    // R5 and R6: a preload always lands, whatever the decoder does.
    a_r5_preload_loads: assert property (@(posedge clk) disable iff (!rst_n)
        preload |=> cnt_q == $past(bus_wdata));

    // R8: a capture event leaves capture-valid set.
    a_r8_capture_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> cap_valid);

    // R10: the compare event comes only on a change of the count onto the compare value.
    a_r10_evt_on_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |-> (cnt_q == cmp_q && cnt_q != $past(cnt_q)));
endmodule

bind quad_pos_counter qpc_checks #(.CNT_W(CNT_W)) u_qpc_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_q     (cnt_q),
    .cmp_q     (cmp_q),
    .cmp_evt   (cmp_evt),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .illegal   (illegal),
    .cap_fire  (cap_fire),
    .cap_valid (cap_valid_q)
);

// File: tb/test_quad_pos_counter.sv
`timescale 1ns/1ps
// Scoreboard bench: the read task queues the expected word, and a monitor
// compares it against bus_rdata shortly after the strobe is set up.
module test_quad_pos_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, cap_in = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmp_evt;

    int tests = 0, fails = 0, pulses = 0;
    logic [1:0] st = 2'b00;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t exp_q[$];
    event  sample_ev;

    always #2.5 clk = ~clk;

    quad_pos_counter i_quad_pos_counter (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .cap_in(cap_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_evt(cmp_evt)
    );

    // Monitor: pop one expected item per read and compare.
    always @(sample_ev) begin
        item_t it;
        #1;
        it = exp_q.pop_front();
        tests++;
        if (bus_rdata !== it.exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
        end
    end

    // Count compare pulses away from the active edge.
    always @(negedge clk) if (rst_n && cmp_evt) pulses++;

    task automatic check_val(input int got, input int exp, input string tag);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a; bus_rd = 1'b1;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        ->sample_ev;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic drive_st();
        enc_a = st[1]; enc_b = st[0];
    endtask

    task automatic step(input bit up);
        case (st)
            2'b00: st = up ? 2'b01 : 2'b10;
            2'b01: st = up ? 2'b11 : 2'b00;
            2'b11: st = up ? 2'b10 : 2'b01;
            default: st = up ? 2'b00 : 2'b11;
        endcase
        drive_st();
        settle();
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        host_read(2'd0, 32'd0, "R1 position");
        host_read(2'd1, 32'd0, "R1 capture");
        host_read(2'd2, 32'd0, "R1 compare");
        host_read(2'd3, 32'd0, "R1 status");

        host_write(2'd2, 32'h1000);
        host_read(2'd2, 32'h1000, "R11 compare readback");

        // R2 counting in both directions
        for (int i = 0; i < 4; i++) step(1'b1);
        host_read(2'd0, 32'd4, "R2 up four");
        for (int i = 0; i < 6; i++) step(1'b0);
        host_read(2'd0, 32'hFFFF_FFFE, "R2 down six");

        // R4 one-cycle glitch on phase A
        enc_a = ~enc_a;
        @(negedge clk);
        drive_st();
        settle();
        host_read(2'd0, 32'hFFFF_FFFE, "R4 glitch ignored");
        host_read(2'd3, 32'd0, "R4 no error");

        // R3 both phases flip at once
        st = st ^ 2'b11;
        drive_st();
        settle();
        host_read(2'd0, 32'hFFFF_FFFE, "R3 count held");
        host_read(2'd3, 32'h2, "R3 error set");
        host_write(2'd3, 32'h2);
        host_read(2'd3, 32'd0, "R3 error cleared");

        // R5 and R7 preload and wrap
        host_write(2'd0, 32'h7FFF_FFFF);
        host_read(2'd0, 32'h7FFF_FFFF, "R5 preload");
        step(1'b1);
        host_read(2'd0, 32'h8000_0000, "R7 wrap up");
        step(1'b0);
        host_read(2'd0, 32'h7FFF_FFFF, "R7 wrap down");

        // R6 preload in the same cycle as a step
        host_write(2'd0, 32'd50);
        settle();
        case (st)
            2'b00: st = 2'b01;
            2'b01: st = 2'b11;
            2'b11: st = 2'b10;
            default: st = 2'b00;
        endcase
        drive_st();
        repeat (5) @(negedge clk);
        host_write(2'd0, 32'd100);
        settle();
        host_read(2'd0, 32'd100, "R6 preload wins");

        // R8 capture on the rising edge
        host_write(2'd0, 32'd500);
        cap_in = 1'b1;
        settle();
        host_read(2'd3, 32'h8, "R8 valid set");
        host_read(2'd1, 32'd500, "R8 capture value");
        host_read(2'd3, 32'h0, "R8 valid cleared by read");

        // R9 falling edge selected: a rising edge does nothing
        cap_in = 1'b0;
        settle();
        host_write(2'd3, 32'h1);
        host_write(2'd0, 32'd700);
        cap_in = 1'b1;
        settle();
        host_read(2'd3, 32'h1, "R9 rising ignored");
        cap_in = 1'b0;
        settle();
        host_read(2'd3, 32'h9, "R9 falling captures");
        host_read(2'd1, 32'd700, "R9 capture value");

        // R10 compare event on arrival only
        host_write(2'd2, 32'd12);
        host_write(2'd0, 32'd10);
        settle();
        pulses = 0;
        step(1'b1);
        step(1'b1);
        check_val(pulses, 1, "R10 one pulse on arrival");
        repeat (20) @(negedge clk);
        check_val(pulses, 1, "R10 no pulse while equal");
        host_read(2'd3, 32'h5, "R10 hit flag");
        step(1'b0);
        step(1'b1);
        check_val(pulses, 2, "R10 pulse on return");
        host_write(2'd3, 32'h5);
        host_read(2'd3, 32'h1, "R10 hit cleared");

        // R11 compare rewritten to the current count
        host_write(2'd2, 32'd5);
        host_write(2'd2, 32'd12);
        settle();
        check_val(pulses, 2, "R11 no pulse on compare write");
        host_read(2'd3, 32'h1, "R11 hit stays clear");

        settle();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule